// File: doc/BRIEF.md
# Descriptor-Based Segment Translator

This block turns a segment-relative offset into a physical address for a protected-mode machine. It has four segment registers. Each one holds an index into a descriptor table in memory, not a base address. When software loads a register, the unit fetches the 64-bit descriptor at that index through a single 32-bit read port. It then keeps the base, the limit and the descriptor privilege level in a local cache, one slot per register.

Every access names a segment register and an offset. The unit adds the cached base to the offset and compares the offset with the cached limit. It also compares the descriptor privilege level with the current privilege level, which it takes from the code segment (register 0). Any violation raises a fault flag, and in that case no address goes out. A flat mode forces every base to zero and every limit to all ones. The privilege check still applies in flat mode.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `ld_busy`, `mem_req` and `res_done` are 0, and every cached slot holds base 0, limit 0 and privilege level 0. So an access with offset 0 issues address 0, and an access with offset 1 raises a limit fault.
- R2: A load that is accepted makes two reads. The first read is at `tbl_base + ld_idx*8` and returns the base. The second read is at that address plus 4. In the second word, bits [29:0] hold the limit (zero-extended) and bits [31:30] hold the privilege level.
- R3: `ld_busy` is 1 from the cycle after a load is accepted until the cycle after the second read returns. While `ld_busy` is 1, `ld_valid` is ignored, and the segment it names keeps its old contents.
- R4: While a load is in progress, an access to the register being loaded raises `acc_stall` in the same cycle and produces no result. An access to any other register goes ahead.
- R5: An access that is not stalled gives `res_done` one cycle later. If it has no fault, `res_issue` is 1 and `res_addr` equals base + offset.
- R6: An offset larger than the limit raises `res_lim_flt`, clears `res_issue` and drives `res_addr` to 0. An offset equal to the limit is allowed.
- R7: The current privilege level is the privilege level of segment 0. An access to a segment whose privilege level is numerically below the current level raises `res_prv_flt` and issues no address.
- R8: While `flat_mode` is 1, the effective base is 0, the limit is all ones and no limit fault occurs, but privilege faults are still raised.
- R9: `mem_req` stays high, with `mem_addr` unchanged, until `mem_rvalid` answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flat_mode | input | 1 | Force base 0 and the maximum limit |
| tbl_base | input | 32 | Descriptor table base address |
| ld_valid | input | 1 | Request a selector load |
| ld_seg | input | 2 | Segment register to load |
| ld_idx | input | IDX_W | Descriptor index |
| ld_busy | output | 1 | Load in progress |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 2 | Segment register used by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_stall | output | 1 | Access held off by a load of its register |
| res_done | output | 1 | Result valid |
| res_issue | output | 1 | Address issued (no fault) |
| res_addr | output | 32 | Physical address, 0 on a fault |
| res_lim_flt | output | 1 | Limit fault |
| res_prv_flt | output | 1 | Privilege fault |

## Verification
The assertions assume the table memory answers only a live request. They also assume that `flat_mode` changes only between accesses and not between an access and its result. The bench's memory model raises `mem_rvalid` only while `mem_req` is high. It changes `flat_mode` only at times when no access is in flight. The assertions also assume a stalled access is simply retried. The bench drops the stalled request and issues a new one, so that assumption holds.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned SEG_AW  = 32;
  localparam int unsigned DPL_W   = 2;
  localparam int unsigned LIM_W   = SEG_AW - DPL_W;
  localparam int unsigned DPL_LSB = LIM_W;

  typedef struct packed {
    logic [SEG_AW-1:0] base;
    logic [SEG_AW-1:0] limit;
    logic [DPL_W-1:0]  dpl;
  } seg_desc_t;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_LO   = 2'd1,
    LD_HI   = 2'd2
  } ld_state_t;
endpackage

// File: rtl/seg_loader.sv
module seg_loader
  import seg_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  parameter int unsigned SEG_N = 4,
  localparam int unsigned SEG_SW = $clog2(SEG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [SEG_SW-1:0] ld_seg,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [SEG_AW-1:0] tbl_base,
  input  logic              mem_rvalid,
  input  logic [SEG_AW-1:0] mem_rdata,
  output logic              busy,
  output logic [SEG_SW-1:0] tgt_seg,
  output logic              mem_req,
  output logic [SEG_AW-1:0] mem_addr,
  output logic              wr_en,
  output seg_desc_t         wr_desc
);
  ld_state_t         state_q, state_d;
  logic [SEG_SW-1:0] seg_q, seg_d;
  logic [SEG_AW-1:0] addr_q, addr_d;
  logic [SEG_AW-1:0] base_q, base_d;
  logic              seg_en, addr_en, base_en;

  always_comb begin
    state_d = state_q;
    seg_d   = ld_seg;
    addr_d  = tbl_base + SEG_AW'({ld_idx, 3'b000});
    base_d  = mem_rdata;
    seg_en  = 1'b0;
    addr_en = 1'b0;
    base_en = 1'b0;
    wr_en   = 1'b0;
    unique case (state_q)
      LD_IDLE: if (ld_valid) begin
        state_d = LD_LO;
        seg_en  = 1'b1;
        addr_en = 1'b1;
      end
      LD_LO: if (mem_rvalid) begin
        state_d = LD_HI;
        base_en = 1'b1;
      end
      LD_HI: if (mem_rvalid) begin
        state_d = LD_IDLE;
        wr_en   = 1'b1;
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      seg_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (seg_en)  seg_q  <= seg_d;
      if (addr_en) addr_q <= addr_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign busy     = (state_q != LD_IDLE);
  assign tgt_seg  = seg_q;
  assign mem_req  = busy;
  assign mem_addr = (state_q == LD_HI) ? addr_q + SEG_AW'(4) : addr_q;

  always_comb begin
    wr_desc.base  = base_q;
    wr_desc.limit = SEG_AW'(mem_rdata[LIM_W-1:0]);
    wr_desc.dpl   = mem_rdata[DPL_LSB +: DPL_W];
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_valid));
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int unsigned SEG_N = 4,
  localparam int unsigned SEG_SW = $clog2(SEG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_SW-1:0] wr_seg,
  input  seg_desc_t         wr_desc,
  output seg_desc_t         desc_o [SEG_N]
);
  for (genvar g = 0; g < SEG_N; g++) begin : g_slot
    seg_desc_t slot_q;
    logic      slot_en;
    assign slot_en = wr_en && (wr_seg == SEG_SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wr_desc;
    end
    assign desc_o[g] = slot_q;
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              flat_mode,
  input  seg_desc_t         desc,
  input  logic [DPL_W-1:0]  cpl,
  input  logic [SEG_AW-1:0] off,
  output logic              res_done,
  output logic              res_issue,
  output logic [SEG_AW-1:0] res_addr,
  output logic              res_lim_flt,
  output logic              res_prv_flt
);
  logic [SEG_AW-1:0] eff_base, eff_lim, addr_d;
  logic              lim_bad, prv_bad, issue_d, lim_d, prv_d;
  logic              done_q, issue_q, lim_q, prv_q;
  logic [SEG_AW-1:0] addr_q;

  always_comb begin
    eff_base = flat_mode ? '0 : desc.base;
    eff_lim  = flat_mode ? '1 : desc.limit;
    lim_bad  = off > eff_lim;
    prv_bad  = desc.dpl < cpl;
    issue_d  = fire && !lim_bad && !prv_bad;
    lim_d    = fire && lim_bad;
    prv_d    = fire && prv_bad;
    addr_d   = issue_d ? eff_base + off : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      issue_q <= 1'b0;
      lim_q   <= 1'b0;
      prv_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      done_q  <= fire;
      issue_q <= issue_d;
      lim_q   <= lim_d;
      prv_q   <= prv_d;
      addr_q  <= addr_d;
    end
  end

  assign res_done    = done_q;
  assign res_issue   = issue_q;
  assign res_addr    = addr_q;
  assign res_lim_flt = lim_q;
  assign res_prv_flt = prv_q;

  // R6
  fault_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_lim_flt || res_prv_flt) |-> !res_issue && res_addr == '0);
  // R8
  flat_no_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_lim_flt |-> !$past(flat_mode));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int unsigned IDX_W    = 13,
  parameter int unsigned SEG_N    = 4,
  parameter int unsigned CODE_SEG = 0,
  localparam int unsigned SEG_SW  = $clog2(SEG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flat_mode,
  input  logic [SEG_AW-1:0] tbl_base,
  input  logic              ld_valid,
  input  logic [SEG_SW-1:0] ld_seg,
  input  logic [IDX_W-1:0]  ld_idx,
  output logic              ld_busy,
  output logic              mem_req,
  output logic [SEG_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [SEG_AW-1:0] mem_rdata,
  input  logic              acc_valid,
  input  logic [SEG_SW-1:0] acc_seg,
  input  logic [SEG_AW-1:0] acc_off,
  output logic              acc_stall,
  output logic              res_done,
  output logic              res_issue,
  output logic [SEG_AW-1:0] res_addr,
  output logic              res_lim_flt,
  output logic              res_prv_flt
);
  logic              wr_en;
  seg_desc_t         wr_desc;
  logic [SEG_SW-1:0] tgt_seg;
  seg_desc_t         desc_all [SEG_N];
  logic              acc_fire;

  seg_loader #(.IDX_W(IDX_W), .SEG_N(SEG_N)) u_loader (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seg(ld_seg),
    .ld_idx(ld_idx), .tbl_base(tbl_base), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(ld_busy), .tgt_seg(tgt_seg),
    .mem_req(mem_req), .mem_addr(mem_addr), .wr_en(wr_en), .wr_desc(wr_desc)
  );

  seg_cache #(.SEG_N(SEG_N)) u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(tgt_seg),
    .wr_desc(wr_desc), .desc_o(desc_all)
  );

  assign acc_stall = acc_valid && ld_busy && (acc_seg == tgt_seg);
  assign acc_fire  = acc_valid && !acc_stall;

  seg_check u_check (
    .clk(clk), .rst_n(rst_n), .fire(acc_fire), .flat_mode(flat_mode),
    .desc(desc_all[acc_seg]), .cpl(desc_all[CODE_SEG].dpl), .off(acc_off),
    .res_done(res_done), .res_issue(res_issue), .res_addr(res_addr),
    .res_lim_flt(res_lim_flt), .res_prv_flt(res_prv_flt)
  );

  // R4
  stall_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |=> !res_done);
  // R5
  done_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(acc_valid));
  // R4
  stall_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> ld_busy);
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  localparam int unsigned IDX_W = 13;
  localparam logic [31:0] TBL = 32'h0004_0000;

  typedef struct packed {
    logic [1:0]  seg;
    logic [31:0] off;
    logic        iss;
    logic        lim;
    logic        prv;
    logic [31:0] addr;
  } vec_t;

  // after loads: seg0<-5 (dpl1,cpl1), seg1<-2 (dpl2), seg2<-8 (dpl0), seg3<-7 (dpl3)
  localparam vec_t VEC [8] = '{
    '{2'd1, 32'h0000_0010, 1'b1, 1'b0, 1'b0, 32'h0001_2010},
    '{2'd1, 32'h0000_0120, 1'b1, 1'b0, 1'b0, 32'h0001_2120},
    '{2'd1, 32'h0000_0121, 1'b0, 1'b1, 1'b0, 32'h0},
    '{2'd3, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0001_7000},
    '{2'd3, 32'h0000_0171, 1'b0, 1'b1, 1'b0, 32'h0},
    '{2'd2, 32'h0000_0004, 1'b0, 1'b0, 1'b1, 32'h0},
    '{2'd2, 32'h0000_0181, 1'b0, 1'b1, 1'b1, 32'h0},
    '{2'd0, 32'h0000_0150, 1'b1, 1'b0, 1'b0, 32'h0001_5150}
  };

  logic clk, rst_n, flat_mode, ld_valid, ld_busy, mem_req, mem_rvalid;
  logic acc_valid, acc_stall, res_done, res_issue, res_lim_flt, res_prv_flt;
  logic [31:0] tbl_base, mem_addr, mem_rdata, acc_off, res_addr;
  logic [1:0] ld_seg, acc_seg;
  logic [IDX_W-1:0] ld_idx;
  logic mem_rdy;
  int errors, checks;

  seg_xlate #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flat_mode(flat_mode), .tbl_base(tbl_base),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_idx(ld_idx), .ld_busy(ld_busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .acc_valid(acc_valid), .acc_seg(acc_seg),
    .acc_off(acc_off), .acc_stall(acc_stall), .res_done(res_done),
    .res_issue(res_issue), .res_addr(res_addr), .res_lim_flt(res_lim_flt),
    .res_prv_flt(res_prv_flt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] desc_word(input logic [31:0] a);
    logic [31:0] idx;
    idx = (a - TBL) >> 3;
    if (!a[2]) return 32'h0001_0000 + idx * 32'h1000;
    return {idx[1:0], 30'(32'h100 + idx * 32'h10)};
  endfunction

  assign mem_rvalid = mem_req && mem_rdy;
  assign mem_rdata  = desc_word(mem_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_acc(input string req, input logic [1:0] seg, input logic [31:0] off,
                        input logic iss, input logic lim, input logic prv,
                        input logic [31:0] addr);
    acc_valid = 1'b1; acc_seg = seg; acc_off = off;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    check(req, {28'd0, res_done, res_issue, res_lim_flt, res_prv_flt},
          {28'd0, 1'b1, iss, lim, prv});
    check(req, res_addr, addr);
  endtask

  task automatic do_load(input logic [1:0] seg, input logic [IDX_W-1:0] idx);
    ld_valid = 1'b1; ld_seg = seg; ld_idx = idx;
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    while (ld_busy) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; flat_mode = 1'b0; tbl_base = TBL; ld_valid = 1'b0;
    ld_seg = '0; ld_idx = '0; acc_valid = 1'b0; acc_seg = '0; acc_off = '0;
    mem_rdy = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, ld_busy}, 32'd0);
    check("R1 req", {31'd0, mem_req}, 32'd0);
    check("R1 done", {31'd0, res_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_acc("R1 zero base", 2'd1, 32'd0, 1'b1, 1'b0, 1'b0, 32'd0);
    do_acc("R1 zero limit", 2'd1, 32'd1, 1'b0, 1'b1, 1'b0, 32'd0);

    // slow load of seg1 <- idx 2
    mem_rdy = 1'b0;
    ld_valid = 1'b1; ld_seg = 2'd1; ld_idx = 13'd2;
    @(posedge clk); @(negedge clk);
    check("R3 busy set", {31'd0, ld_busy}, 32'd1);
    check("R2 first addr", mem_addr, TBL + 32'd16);
    ld_seg = 2'd3; ld_idx = 13'd7;            // R3: must be ignored
    acc_valid = 1'b1; acc_seg = 2'd1; acc_off = 32'd0;
    #1 check("R4 stall same seg", {31'd0, acc_stall}, 32'd1);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    check("R4 no result", {31'd0, res_done}, 32'd0);
    check("R9 held addr", mem_addr, TBL + 32'd16);
    acc_seg = 2'd2;
    #1 check("R4 other seg", {31'd0, acc_stall}, 32'd0);
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    check("R4 other seg result", {30'd0, res_done, res_issue}, 32'd3);
    mem_rdy = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 second addr", mem_addr, TBL + 32'd20);
    @(posedge clk); @(negedge clk);
    check("R3 busy clear", {31'd0, ld_busy}, 32'd0);
    do_acc("R3 ignored load", 2'd3, 32'd1, 1'b0, 1'b1, 1'b0, 32'd0);

    do_load(2'd0, 13'd5);
    do_load(2'd2, 13'd8);
    do_load(2'd3, 13'd7);
    for (int i = 0; i < 8; i++)
      do_acc("R5/R6/R7 table", VEC[i].seg, VEC[i].off, VEC[i].iss,
             VEC[i].lim, VEC[i].prv, VEC[i].addr);

    do_load(2'd0, 13'd3);                     // cpl becomes 3
    do_acc("R7 cpl raised", 2'd1, 32'd0, 1'b0, 1'b0, 1'b1, 32'd0);
    do_acc("R7 equal level", 2'd3, 32'd0, 1'b1, 1'b0, 1'b0, 32'h0001_7000);

    flat_mode = 1'b1;
    @(negedge clk);
    do_acc("R8 flat max", 2'd3, 32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFF0);
    do_acc("R8 flat base", 2'd3, 32'h0000_0040, 1'b1, 1'b0, 1'b0, 32'h0000_0040);
    do_acc("R8 flat priv", 2'd1, 32'hFFFF_0000, 1'b0, 1'b0, 1'b1, 32'd0);
    flat_mode = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule